// File: doc/BRIEF.md
# Per-Module Interrupt Status Controller

This block gathers the interrupt lines of four attached modules, two lines per module, into one host interrupt request. A small 16-bit register window holds a control byte for every module and a shared 16-bit status word. Each control byte turns each of its module's lines on or off and picks whether the line is handled as a level or as an edge. The status word shows the current state of every enabled line and a sticky timeout flag for each module.

Level-handled lines keep the host interrupt raised for as long as any of their status bits is set. Edge-handled lines give a single-cycle pulse when their status bit goes from clear to set. The host clears line interrupts by sending clear requests to the modules. It does this by writing ones to the status word, or by reading offset 0 or 2 of a module's interrupt space. The module drops its line in response, and the status bit follows. Timeout flags are set by a rising edge on a per-module timeout input and are cleared by writing a one to them.

Top module: `ictl_top`

## Requirements
- R1: A synchronous active-low reset clears every control byte, the status word, `host_irq` and `line_clr`.
- R2: Status bit 2*m+l (m = module 0..3, l = line 0..1) takes the level of `line_in[2*m+l]` at each clock edge while that line is enabled. The new value is readable in the cycle after the edge.
- R3: While a line's enable bit is clear, its status bit keeps its value whatever the line does, and the line cannot raise `host_irq`.
- R4: `host_irq` is high in the cycle after an edge at which any line status bit in level mode is set (edge-select bit clear). It is low once none are set and no edge pulse is due.
- R5: An enabled line in edge mode whose status bit goes from 0 to 1 drives `host_irq` high for exactly one cycle.
- R6: Word index 0 (byte offset 0x00, revision) and word index 5 (0x0A, reset) read as zero, and writes to them change nothing. Word index 7 reads zero. Word indices 1 to 4 (0x02 to 0x08) hold the control bytes of modules A to D, and word index 6 (0x0C) is the status word.
- R7: The control byte sits in bits 7:0 of its word, and bits 15:8 read as zero. Bit 6 enables line 0 and bit 7 enables line 1. Bit 4 selects edge mode for line 0 and bit 5 for line 1. Bits 0 to 3 (clock rate, recovery, timeout enable, error enable) are stored and read back only.
- R8: Status bit 12+m is set by a rising edge on `tmo_in[m]` and cleared by writing 1 to it at word index 6. A set at the same edge as a clear wins.
- R9: Writing word index 6 with bit 2*m+l set pulses `line_clr[2*m+l]` for one cycle after the write. Bits 11:8 of the status word always read as zero, and writes to them have no effect.
- R10: An acknowledge read (`ack_rd`) of module `ack_mod` at `ack_off` 0 or 2 pulses `line_clr` for line 0 or 1 of that module in the next cycle. It does so only if that line's status bit is set and the line is in level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 3 | Register word index (byte offset divided by two) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_word`, combinational |
| line_in | input | 8 | Module interrupt lines, bit 2*m+l |
| tmo_in | input | 4 | Per-module timeout inputs |
| ack_rd | input | 1 | One-cycle interrupt-space read strobe |
| ack_mod | input | 2 | Module addressed by the interrupt-space read |
| ack_off | input | 6 | Offset of the interrupt-space read |
| host_irq | output | 1 | Aggregated host interrupt |
| line_clr | output | 8 | One-cycle clear requests to module lines |

## Verification
The assertions assume that the register strobe, the acknowledge strobe and the timeout inputs are synchronous to `clk` and are driven with defined values once reset is released. They also assume that `line_in` changes only between edges. The stimulus changes every input on the falling edge and holds it across the next rising edge. It keeps strobes at zero outside the cycles in which they are used, and it holds reset for several cycles at the start.

// File: rtl/ictl_pkg.sv
// Shared constants and types for the interrupt status controller.
// Assumes four modules with two lines each, which fixes the 16-bit status layout.
package ictl_pkg;
    localparam int N_MOD     = 4;
    localparam int N_LINE    = 2;
    localparam int N_SRC     = N_MOD * N_LINE;
    localparam int STS_W     = 16;
    localparam int ERR_LSB   = 8;
    localparam int TMO_LSB   = 12;
    localparam int WORD_W    = 3;
    localparam int MOD_W     = $clog2(N_MOD);
    localparam int ACK_OFF_W = 6;
    localparam int CTRL_W    = 8;

    // Word indices inside the register window
    localparam logic [WORD_W-1:0] W_REV   = 3'd0;
    localparam logic [WORD_W-1:0] W_CTRL0 = 3'd1;
    localparam logic [WORD_W-1:0] W_RST   = 3'd5;
    localparam logic [WORD_W-1:0] W_STS   = 3'd6;

    // Per-module control byte, most significant field first
    typedef struct packed {
        logic [N_LINE-1:0] en;
        logic [N_LINE-1:0] edg;
        logic              err_ie;
        logic              tmo_ie;
        logic              recov;
        logic              rate_sel;
    } ctrl_t;
endpackage

// File: rtl/ictl_regs.sv
// Register window: control bytes, address decode and read mux.
// Assumes 16-bit accesses addressed by word index; unmapped words read zero.
module ictl_regs
    import ictl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [WORD_W-1:0]   reg_word,
    input  logic [CTRL_W-1:0]   wdata_lo,
    input  logic [STS_W-1:0]    sts_q,
    output logic                sts_wr,
    output logic [N_SRC-1:0]    en_mask,
    output logic [N_SRC-1:0]    edge_mask,
    output logic [STS_W-1:0]    reg_rdata
);
    ctrl_t ctrl_q [N_MOD];

    // Control byte storage, one byte per module
    always_ff @(posedge clk) begin
        for (int m = 0; m < N_MOD; m++) begin
            if (!rst_n) begin
                ctrl_q[m] <= '0;
            end else if (reg_wr && (reg_word == WORD_W'(int'(W_CTRL0) + m))) begin
                ctrl_q[m] <= ctrl_t'(wdata_lo);
            end
        end
    end

    // Flatten per-module enable and edge-select fields into line masks
    for (genvar m = 0; m < N_MOD; m++) begin : g_mask
        assign en_mask[m*N_LINE +: N_LINE]   = ctrl_q[m].en;
        assign edge_mask[m*N_LINE +: N_LINE] = ctrl_q[m].edg;
    end

    // Status write strobe
    assign sts_wr = reg_wr && (reg_word == W_STS);

    // Read data mux
    always_comb begin
        reg_rdata = '0;
        if (reg_word == W_STS) begin
            reg_rdata = sts_q;
        end else begin
            for (int m = 0; m < N_MOD; m++) begin
                if (reg_word == WORD_W'(int'(W_CTRL0) + m)) begin
                    reg_rdata = {{(STS_W-CTRL_W){1'b0}}, ctrl_q[m]};
                end
            end
        end
    end
endmodule

// File: rtl/ictl_status.sv
// Status word: per-line state following enabled lines, sticky timeout flags.
// Assumes inputs are synchronous; error bits are held at zero.
module ictl_status
    import ictl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    line_in,
    input  logic [N_SRC-1:0]    en_mask,
    input  logic [N_MOD-1:0]    tmo_in,
    input  logic [N_MOD-1:0]    tmo_clr,
    output logic [N_SRC-1:0]    line_sts,
    output logic [N_SRC-1:0]    line_nxt,
    output logic [N_SRC-1:0]    rise,
    output logic [STS_W-1:0]    sts_q
);
    logic [N_MOD-1:0] tmo_sts;
    logic [N_MOD-1:0] tmo_q;

    for (genvar k = 0; k < N_SRC; k++) begin : g_line
        // Next state: follow the line when enabled, else hold
        assign line_nxt[k] = en_mask[k] ? line_in[k] : line_sts[k];
        // Line status register
        always_ff @(posedge clk) begin
            if (!rst_n) line_sts[k] <= 1'b0;
            else        line_sts[k] <= line_nxt[k];
        end
    end

    // Enabled lines that are about to go from clear to set
    assign rise = en_mask & line_in & ~line_sts;

    for (genvar m = 0; m < N_MOD; m++) begin : g_tmo
        // Timeout edge detect and sticky flag, set beats clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tmo_q[m]   <= 1'b0;
                tmo_sts[m] <= 1'b0;
            end else begin
                tmo_q[m] <= tmo_in[m];
                if (tmo_in[m] && !tmo_q[m]) tmo_sts[m] <= 1'b1;
                else if (tmo_clr[m])        tmo_sts[m] <= 1'b0;
            end
        end
    end

    assign sts_q = {tmo_sts, {(TMO_LSB-ERR_LSB){1'b0}}, {(ERR_LSB-N_SRC){1'b0}}, line_sts};
endmodule

// File: rtl/ictl_irq.sv
// Host interrupt aggregation and clear-request generation.
// Assumes ack_rd is a one-cycle strobe; masks are the pre-edge control values.
module ictl_irq
    import ictl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     line_sts,
    input  logic [N_SRC-1:0]     line_nxt,
    input  logic [N_SRC-1:0]     edge_mask,
    input  logic [N_SRC-1:0]     rise,
    input  logic [N_SRC-1:0]     clr_req,
    input  logic                 ack_rd,
    input  logic [MOD_W-1:0]     ack_mod,
    input  logic [ACK_OFF_W-1:0] ack_off,
    output logic                 host_irq,
    output logic [N_SRC-1:0]     line_clr
);
    logic [N_SRC-1:0] ack_hit;
    logic             lvl_any;
    logic             edge_any;

    // Acknowledge decode: offset 2*l of module m hits line 2*m+l
    for (genvar k = 0; k < N_SRC; k++) begin : g_ack
        assign ack_hit[k] = ack_rd
                         && (ack_mod == MOD_W'(k / N_LINE))
                         && (ack_off == ACK_OFF_W'(2 * (k % N_LINE)))
                         && line_sts[k] && !edge_mask[k];
    end

    assign lvl_any  = |(line_nxt & ~edge_mask);
    assign edge_any = |(rise & edge_mask);

    // Registered host interrupt and clear requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_irq <= 1'b0;
            line_clr <= '0;
        end else begin
            host_irq <= lvl_any | edge_any;
            line_clr <= clr_req | ack_hit;
        end
    end
endmodule

// File: rtl/ictl_top.sv
// Interrupt status controller top: ties register window, status and host interrupt.
// Assumes a single clock domain and synchronous active-low reset.
module ictl_top
    import ictl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [WORD_W-1:0]    reg_word,
    input  logic [STS_W-1:0]     reg_wdata,
    output logic [STS_W-1:0]     reg_rdata,
    input  logic [N_SRC-1:0]     line_in,
    input  logic [N_MOD-1:0]     tmo_in,
    input  logic                 ack_rd,
    input  logic [MOD_W-1:0]     ack_mod,
    input  logic [ACK_OFF_W-1:0] ack_off,
    output logic                 host_irq,
    output logic [N_SRC-1:0]     line_clr
);
    logic             sts_wr;
    logic [N_SRC-1:0] en_mask;
    logic [N_SRC-1:0] edge_mask;
    logic [N_SRC-1:0] line_sts;
    logic [N_SRC-1:0] line_nxt;
    logic [N_SRC-1:0] rise;
    logic [STS_W-1:0] sts_q;
    logic [N_MOD-1:0] tmo_clr;
    logic [N_SRC-1:0] clr_req;

    assign tmo_clr = sts_wr ? reg_wdata[TMO_LSB +: N_MOD] : '0;
    assign clr_req = sts_wr ? reg_wdata[N_SRC-1:0]        : '0;

    ictl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_word  (reg_word),
        .wdata_lo  (reg_wdata[CTRL_W-1:0]),
        .sts_q     (sts_q),
        .sts_wr    (sts_wr),
        .en_mask   (en_mask),
        .edge_mask (edge_mask),
        .reg_rdata (reg_rdata)
    );

    ictl_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .en_mask  (en_mask),
        .tmo_in   (tmo_in),
        .tmo_clr  (tmo_clr),
        .line_sts (line_sts),
        .line_nxt (line_nxt),
        .rise     (rise),
        .sts_q    (sts_q)
    );

    ictl_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sts  (line_sts),
        .line_nxt  (line_nxt),
        .edge_mask (edge_mask),
        .rise      (rise),
        .clr_req   (clr_req),
        .ack_rd    (ack_rd),
        .ack_mod   (ack_mod),
        .ack_off   (ack_off),
        .host_irq  (host_irq),
        .line_clr  (line_clr)
    );
endmodule

// File: rtl/ictl_chk.sv
// Property checker for ictl_top, attached by bind below.
// Assumes synchronous inputs; all properties are gated by reset history.
module ictl_chk
    import ictl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] line_sts,
    input logic [N_SRC-1:0] en_mask,
    input logic [N_SRC-1:0] edge_mask,
    input logic [STS_W-1:0] sts_q,
    input logic [N_MOD-1:0] tmo_in,
    input logic             reg_wr,
    input logic             ack_rd,
    input logic             host_irq,
    input logic [N_SRC-1:0] line_clr
);
    for (genvar k = 0; k < N_SRC; k++) begin : g_k
        AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(en_mask[k])) |-> (line_sts[k] == $past(line_sts[k]))); // R3
    end

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && |(line_sts & ~$past(edge_mask))) |-> host_irq); // R4

    AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && |line_clr) |-> $past(reg_wr || ack_rd)); // R10

    for (genvar m = 0; m < N_MOD; m++) begin : g_m
        AST_TMO_SET: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n, 2) && $past(rst_n) && $past(tmo_in[m]) && !$past(tmo_in[m], 2))
            |-> sts_q[TMO_LSB + m]); // R8
    end
endmodule

bind ictl_top ictl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_sts  (line_sts),
    .en_mask   (en_mask),
    .edge_mask (edge_mask),
    .sts_q     (sts_q),
    .tmo_in    (tmo_in),
    .reg_wr    (reg_wr),
    .ack_rd    (ack_rd),
    .host_irq  (host_irq),
    .line_clr  (line_clr)
);

// File: tb/test_ictl_top.sv
`timescale 1ns/1ps
module test_ictl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_word = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  line_in = '0;
    logic [3:0]  tmo_in = '0;
    logic        ack_rd = 1'b0;
    logic [1:0]  ack_mod = '0;
    logic [5:0]  ack_off = '0;
    logic        host_irq;
    logic [7:0]  line_clr;

    int total = 0;
    int fails = 0;

    // Reference model state
    logic [7:0]  m_ctrl [4];
    logic [15:0] m_sts = '0;
    logic [3:0]  m_tq = '0;
    logic        m_irq = 1'b0;
    logic        m_pulse = 1'b0;
    logic [7:0]  m_clr = '0;
    logic        m_ack = 1'b0;

    always #4 clk = ~clk;

    ictl_top i_ictl_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_in(line_in),
        .tmo_in(tmo_in), .ack_rd(ack_rd), .ack_mod(ack_mod), .ack_off(ack_off),
        .host_irq(host_irq), .line_clr(line_clr)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] model_read(logic [2:0] w);
        if (w == 3'd6) return m_sts;
        if (w >= 3'd1 && w <= 3'd4) return {8'h00, m_ctrl[int'(w) - 1]};
        return 16'h0000;
    endfunction

    function automatic string rtag(logic [2:0] w);
        if (w == 3'd6) return "R2";
        if (w >= 3'd1 && w <= 3'd4) return "R7";
        return "R6";
    endfunction

    // Behavioural model advanced at each rising edge from the held inputs
    task automatic model_step();
        logic [15:0] ns;
        logic pulse, lvl, ackf;
        logic [7:0] clr;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_ctrl[i] = 8'h00;
            m_sts = '0; m_tq = '0; m_irq = 0; m_pulse = 0; m_clr = '0; m_ack = 0;
            return;
        end
        ns = m_sts; pulse = 0; lvl = 0; ackf = 0; clr = '0;
        for (int k = 0; k < 8; k++) begin
            int m = k / 2;
            int l = k % 2;
            logic en = m_ctrl[m][6 + l];
            logic ed = m_ctrl[m][4 + l];
            if (en) begin
                if (ed && line_in[k] && !m_sts[k]) pulse = 1;
                ns[k] = line_in[k];
            end
            if (reg_wr && reg_word == 3'd6 && reg_wdata[k]) clr[k] = 1;
            if (ack_rd && int'(ack_mod) == m && int'(ack_off) == 2 * l && m_sts[k] && !ed) begin
                clr[k] = 1; ackf = 1;
            end
        end
        for (int k = 0; k < 8; k++) if (ns[k] && !m_ctrl[k / 2][4 + k % 2]) lvl = 1;
        for (int m = 0; m < 4; m++) begin
            if (tmo_in[m] && !m_tq[m]) ns[12 + m] = 1;
            else if (reg_wr && reg_word == 3'd6 && reg_wdata[12 + m]) ns[12 + m] = 0;
        end
        m_tq = tmo_in;
        if (reg_wr && reg_word >= 3'd1 && reg_word <= 3'd4) m_ctrl[int'(reg_word) - 1] = reg_wdata[7:0];
        m_sts = ns; m_irq = pulse | lvl; m_pulse = pulse; m_clr = clr; m_ack = ackf;
    endtask

    // One clock: model at the rising edge, compare at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(rtag(reg_word), reg_rdata, model_read(reg_word));
        chk(m_pulse ? "R5" : "R4", host_irq, m_irq);
        chk(m_ack ? "R10" : "R9", line_clr, m_clr);
    endtask

    task automatic wr(logic [2:0] w, logic [15:0] d);
        reg_wr = 1; reg_word = w; reg_wdata = d;
        cyc();
        reg_wr = 0;
    endtask

    task automatic rd(logic [2:0] w, string tag, logic [15:0] exp);
        reg_word = w;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        #(200000 * 8);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_ctrl[i] = 8'h00;
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1: reset state
        rd(3'd6, "R1", 16'h0000);
        rd(3'd1, "R1", 16'h0000);
        chk("R1", host_irq, 0);
        chk("R1", line_clr, 0);
        // R7: control byte layout, upper byte discarded
        wr(3'd1, 16'hFFC0);
        rd(3'd1, "R7", 16'h00C0);
        // R2, R4: level line of module A
        line_in = 8'h01; cyc();
        rd(3'd6, "R2", 16'h0001);
        chk("R4", host_irq, 1);
        cyc(); chk("R4", host_irq, 1);
        // R10: acknowledge line 0 of module A
        ack_rd = 1; ack_mod = 0; ack_off = 0; cyc(); ack_rd = 0;
        chk("R10", line_clr, 8'h01);
        cyc(); chk("R10", line_clr, 8'h00);
        line_in = 8'h00; cyc();
        chk("R4", host_irq, 0);
        rd(3'd6, "R2", 16'h0000);
        // R5: edge line 0 of module B
        wr(3'd2, 16'h0050);
        line_in = 8'h04; cyc();
        chk("R5", host_irq, 1);
        cyc(); chk("R5", host_irq, 0);
        rd(3'd6, "R2", 16'h0004);
        // R10: acknowledge of an edge line has no effect
        ack_rd = 1; ack_mod = 1; ack_off = 0; cyc(); ack_rd = 0;
        chk("R10", line_clr, 8'h00);
        // R10: acknowledge of a clear level line has no effect
        ack_rd = 1; ack_mod = 0; ack_off = 2; cyc(); ack_rd = 0;
        chk("R10", line_clr, 8'h00);
        // R3: module C lines disabled
        line_in = 8'h14; cyc(); cyc();
        rd(3'd6, "R3", 16'h0004);
        chk("R3", host_irq, 0);
        // R9: status write sends clear requests, error bits stay zero
        wr(3'd6, 16'h0F05);
        chk("R9", line_clr, 8'h05);
        rd(3'd6, "R9", 16'h0004);
        // R8: timeout set, clear, set beats clear
        tmo_in = 4'h8; cyc();
        rd(3'd6, "R8", 16'h8004);
        wr(3'd6, 16'h8000);
        rd(3'd6, "R8", 16'h0004);
        tmo_in = 4'h0; cyc();
        tmo_in = 4'h8;
        wr(3'd6, 16'h8000);
        rd(3'd6, "R8", 16'h8004);
        // R6: revision and reset words
        wr(3'd0, 16'hFFFF);
        rd(3'd0, "R6", 16'h0000);
        wr(3'd5, 16'hFFFF);
        rd(3'd5, "R6", 16'h0000);
        rd(3'd1, "R6", 16'h00C0);
        rd(3'd7, "R6", 16'h0000);
        // R4: mixed modes on module B, then line 1 switched to edge
        wr(3'd2, 16'h00D0);
        line_in = 8'h1C; cyc();
        chk("R4", host_irq, 1);
        wr(3'd2, 16'h00F0);
        cyc();
        chk("R4", host_irq, 0);
        // R1: reset in the middle of activity
        rst_n = 0; cyc(); cyc();
        rst_n = 1; line_in = 8'h00; tmo_in = 4'h0; cyc();
        rd(3'd2, "R1", 16'h0000);
        rd(3'd6, "R1", 16'h0000);
        chk("R1", host_irq, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule